// File: doc/BRIEF.md
# Tagged Address Translation Cache

This block is a small, fully associative cache of page translations that sits in front of a page-table walker. Each entry pairs a virtual page number with a physical page number, the page's permission flags and an address-space tag. A lookup compares the presented page number, and the tag when tagging is enabled, against every entry in parallel. It answers in the same cycle with a hit, a miss or a permission fault.

On a miss the walker resolves the translation and presents the result on the fill port, and the block installs it. Slots are chosen round-robin, unless the same key is already cached, in which case that entry is rewritten in place. A fence input invalidates every entry. A write to the root page-table register does the same when tagging is off. When tagging is on, a root write leaves the contents alone, because the address-space tag already keeps processes apart.

Top module: `tlb_xlate`

## Requirements
- R1: A lookup whose key matches a valid entry and passes the permission check raises `lk_hit` in the same cycle, with that entry's PPN on `lk_ppn` and its flags on `lk_flags`.
- R2: When `lk_valid` is high, exactly one of `lk_hit`, `lk_miss` and `lk_fault` is high. When `lk_valid` is low, all three are low. A lookup whose key matches no valid entry raises `lk_miss`.
- R3: A fill presented without a flush is visible to a lookup of the same key from the next cycle on.
- R4: A fill of a new key is written to the slot under a round-robin pointer, which then advances by one modulo 16. Starting from reset, the 17th distinct fill evicts the first.
- R5: A fill whose key is already cached rewrites that entry in place and does not advance the pointer.
- R6: `fence` high invalidates all 16 entries at the next clock edge.
- R7: `root_wr` invalidates all entries when `ctx_tag_en` is 0, and has no effect when it is 1.
- R8: With `ctx_tag_en` = 1, a key matches only if both the VPN and the tag are equal. With `ctx_tag_en` = 0, the tag is ignored.
- R9: Flag bits are V=0, R=1, W=2, X=3, U=4. Access codes are 0 load, 1 store, 2 fetch; code 3 always faults. A matching lookup faults if V is clear, if the bit for its access type is clear, or if `lk_user` is set and U is clear. A fault still drives the entry's PPN and flags and changes no entry.
- R10: A lookup in a cycle where a flush is triggered reports a miss, and a fill in that cycle is dropped.
- R11: After reset every entry is invalid and the pointer is at slot 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctx_tag_en | input | 1 | Enables address-space tagging |
| lk_valid | input | 1 | Lookup request |
| lk_vpn | input | 27 | Lookup virtual page number |
| lk_asid | input | 16 | Lookup address-space tag |
| lk_acc | input | 2 | Access type (0 load, 1 store, 2 fetch) |
| lk_user | input | 1 | Access is from user mode |
| lk_hit | output | 1 | Translation found and permitted |
| lk_miss | output | 1 | No translation cached |
| lk_fault | output | 1 | Translation found but permission denied |
| lk_ppn | output | 44 | Physical page number of the matching entry |
| lk_flags | output | 8 | Flags of the matching entry |
| fill_valid | input | 1 | Install a walker result |
| fill_vpn | input | 27 | Fill virtual page number |
| fill_asid | input | 16 | Fill address-space tag |
| fill_ppn | input | 44 | Fill physical page number |
| fill_flags | input | 8 | Fill flags |
| fence | input | 1 | Invalidate all entries |
| root_wr | input | 1 | Root page-table register written |

## Verification
The assertions assume that `ctx_tag_en` changes only together with a fence. This rules out two valid entries that match the same untagged key. The assertion that a fill is visible one cycle later also requires `ctx_tag_en` to hold steady across those two cycles. The stimulus keeps to both rules. It holds `ctx_tag_en` fixed within each phase and issues a fence at every phase change. Random keys are drawn from a small pool so that hits, duplicate fills and evictions all occur often.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
    localparam int VPN_W   = 27;
    localparam int PPN_W   = 44;
    localparam int FLG_W   = 8;
    localparam int ASID_W  = 16;
    localparam int ENTRIES = 16;
    localparam int IDX_W   = $clog2(ENTRIES);

    localparam int FB_V = 0;
    localparam int FB_R = 1;
    localparam int FB_W = 2;
    localparam int FB_X = 3;
    localparam int FB_U = 4;

    typedef enum logic [1:0] {
        ACC_LOAD  = 2'd0,
        ACC_STORE = 2'd1,
        ACC_FETCH = 2'd2,
        ACC_RSVD  = 2'd3
    } acc_e;

    typedef struct packed {
        logic              vld;
        logic [ASID_W-1:0] asid;
        logic [VPN_W-1:0]  vpn;
        logic [PPN_W-1:0]  ppn;
        logic [FLG_W-1:0]  flg;
    } tlb_ent_t;

    function automatic logic perm_ok(input logic [FLG_W-1:0] f,
                                     input logic [1:0] acc,
                                     input logic usr);
        logic need;
        case (acc_e'(acc))
            ACC_LOAD:  need = f[FB_R];
            ACC_STORE: need = f[FB_W];
            ACC_FETCH: need = f[FB_X];
            default:   need = 1'b0;
        endcase
        return f[FB_V] && need && (!usr || f[FB_U]);
    endfunction
endpackage

// File: rtl/tlb_cam.sv
module tlb_cam
    import tlb_pkg::*;
(
    input  tlb_ent_t [ENTRIES-1:0] ents,
    input  logic [VPN_W-1:0]       key_vpn,
    input  logic [ASID_W-1:0]      key_asid,
    input  logic                   use_asid,
    output logic                   any,
    output logic [IDX_W-1:0]       idx
);
    logic [ENTRIES-1:0] match;

    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        assign match[g] = ents[g].vld && (ents[g].vpn == key_vpn) &&
                          (!use_asid || ents[g].asid == key_asid);
    end

    always_comb begin
        idx = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (match[i]) idx = IDX_W'(i);
        end
    end

    assign any = |match;
endmodule

// File: rtl/tlb_rr.sv
module tlb_rr
    import tlb_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             adv,
    output logic [IDX_W-1:0] ptr
);
    always_ff @(posedge clk) begin
        if (rst)      ptr <= '0;
        else if (adv) ptr <= ptr + 1'b1;
    end
endmodule

// File: rtl/tlb_store.sv
module tlb_store
    import tlb_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   flush,
    input  logic                   wr_en,
    input  logic [IDX_W-1:0]       wr_idx,
    input  tlb_ent_t               wr_ent,
    output tlb_ent_t [ENTRIES-1:0] ents
);
    for (genvar g = 0; g < ENTRIES; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst || flush) begin
                ents[g] <= '0;
            end else if (wr_en && wr_idx == IDX_W'(g)) begin
                ents[g] <= wr_ent;
            end
        end
    end
endmodule

// File: rtl/tlb_xlate.sv
module tlb_xlate
    import tlb_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              ctx_tag_en,
    input  logic              lk_valid,
    input  logic [VPN_W-1:0]  lk_vpn,
    input  logic [ASID_W-1:0] lk_asid,
    input  logic [1:0]        lk_acc,
    input  logic              lk_user,
    output logic              lk_hit,
    output logic              lk_miss,
    output logic              lk_fault,
    output logic [PPN_W-1:0]  lk_ppn,
    output logic [FLG_W-1:0]  lk_flags,
    input  logic              fill_valid,
    input  logic [VPN_W-1:0]  fill_vpn,
    input  logic [ASID_W-1:0] fill_asid,
    input  logic [PPN_W-1:0]  fill_ppn,
    input  logic [FLG_W-1:0]  fill_flags,
    input  logic              fence,
    input  logic              root_wr
);
    tlb_ent_t [ENTRIES-1:0] ents;
    tlb_ent_t               sel, wr_ent;
    logic                   flush, lk_any, fl_any, wr_en, ok;
    logic [IDX_W-1:0]       lk_idx, fl_idx, rr_ptr, wr_idx;

    assign flush = fence || (root_wr && !ctx_tag_en);

    tlb_cam u_lk_cam (
        .ents(ents), .key_vpn(lk_vpn), .key_asid(lk_asid),
        .use_asid(ctx_tag_en), .any(lk_any), .idx(lk_idx)
    );

    tlb_cam u_fl_cam (
        .ents(ents), .key_vpn(fill_vpn), .key_asid(fill_asid),
        .use_asid(ctx_tag_en), .any(fl_any), .idx(fl_idx)
    );

    assign sel      = ents[lk_idx];
    assign ok       = perm_ok(sel.flg, lk_acc, lk_user);
    assign lk_hit   = lk_valid && !flush && lk_any && ok;
    assign lk_fault = lk_valid && !flush && lk_any && !ok;
    assign lk_miss  = lk_valid && (flush || !lk_any);
    assign lk_ppn   = lk_any ? sel.ppn : '0;
    assign lk_flags = lk_any ? sel.flg : '0;

    assign wr_en  = fill_valid && !flush;
    assign wr_idx = fl_any ? fl_idx : rr_ptr;
    always_comb begin
        wr_ent      = '0;
        wr_ent.vld  = 1'b1;
        wr_ent.asid = fill_asid;
        wr_ent.vpn  = fill_vpn;
        wr_ent.ppn  = fill_ppn;
        wr_ent.flg  = fill_flags;
    end

    tlb_rr u_rr (
        .clk(clk), .rst(rst), .adv(wr_en && !fl_any), .ptr(rr_ptr)
    );

    tlb_store u_store (
        .clk(clk), .rst(rst), .flush(flush), .wr_en(wr_en),
        .wr_idx(wr_idx), .wr_ent(wr_ent), .ents(ents)
    );
endmodule

// File: rtl/tlb_xlate_chk.sv
module tlb_xlate_chk
    import tlb_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              ctx_tag_en,
    input logic              lk_valid,
    input logic [VPN_W-1:0]  lk_vpn,
    input logic [ASID_W-1:0] lk_asid,
    input logic [1:0]        lk_acc,
    input logic              lk_user,
    input logic              lk_hit,
    input logic              lk_miss,
    input logic              lk_fault,
    input logic [PPN_W-1:0]  lk_ppn,
    input logic [FLG_W-1:0]  lk_flags,
    input logic              fill_valid,
    input logic [VPN_W-1:0]  fill_vpn,
    input logic [ASID_W-1:0] fill_asid,
    input logic [PPN_W-1:0]  fill_ppn,
    input logic [FLG_W-1:0]  fill_flags,
    input logic              fence,
    input logic              root_wr
);
    assert_one_result_R2: assert property (@(posedge clk) disable iff (rst)
        lk_valid |-> $countones({lk_hit, lk_miss, lk_fault}) == 1);

    assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (rst)
        !lk_valid |-> !(lk_hit || lk_miss || lk_fault));

    assert_fence_clears_R6: assert property (@(posedge clk) disable iff (rst)
        fence |=> !(lk_hit || lk_fault));

    assert_root_clears_R7: assert property (@(posedge clk) disable iff (rst)
        (root_wr && !ctx_tag_en) |=> !(lk_hit || lk_fault));

    assert_flush_cycle_miss_R10: assert property (@(posedge clk) disable iff (rst)
        ((fence || (root_wr && !ctx_tag_en)) && lk_valid) |-> lk_miss);

    assert_fill_visible_R3: assert property (@(posedge clk) disable iff (rst)
        (fill_valid && !fence && !(root_wr && !ctx_tag_en)) ##1
        (lk_valid && $stable(ctx_tag_en) && !fence && !(root_wr && !ctx_tag_en) &&
         lk_vpn == $past(fill_vpn) && (!ctx_tag_en || lk_asid == $past(fill_asid)))
        |-> (!lk_miss && lk_ppn == $past(fill_ppn)));

    assert_store_needs_w_R9: assert property (@(posedge clk) disable iff (rst)
        (lk_hit && lk_acc == 2'd1) |-> lk_flags[FB_W]);

    assert_user_needs_u_R9: assert property (@(posedge clk) disable iff (rst)
        (lk_hit && lk_user) |-> lk_flags[FB_U]);
endmodule

bind tlb_xlate tlb_xlate_chk u_chk (.*);

// File: tb/tlb_xlate_test.sv
module tlb_xlate_test;
    localparam int CLK_PERIOD = 10;
    localparam int N = 16;

    logic        clk = 0, rst = 1, ctx_tag_en = 1;
    logic        lk_valid = 0, lk_user = 0;
    logic [26:0] lk_vpn = 0;
    logic [15:0] lk_asid = 0;
    logic [1:0]  lk_acc = 0;
    logic        lk_hit, lk_miss, lk_fault;
    logic [43:0] lk_ppn;
    logic [7:0]  lk_flags;
    logic        fill_valid = 0;
    logic [26:0] fill_vpn = 0;
    logic [15:0] fill_asid = 0;
    logic [43:0] fill_ppn = 0;
    logic [7:0]  fill_flags = 0;
    logic        fence = 0, root_wr = 0;

    int checks = 0, fails = 0;

    logic        m_vld  [N];
    logic [26:0] m_vpn  [N];
    logic [15:0] m_asid [N];
    logic [43:0] m_ppn  [N];
    logic [7:0]  m_flg  [N];
    int          m_ptr;

    tlb_xlate uut (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic exp_allow(logic [7:0] f, logic [1:0] acc, logic usr);
        logic bitok;
        bitok = (acc == 2'd0) ? f[1] : (acc == 2'd1) ? f[2] : (acc == 2'd2) ? f[3] : 1'b0;
        return f[0] && bitok && (!usr || f[4]);
    endfunction

    function automatic int find(logic [26:0] v, logic [15:0] a);
        for (int i = 0; i < N; i++)
            if (m_vld[i] && m_vpn[i] == v && (!ctx_tag_en || m_asid[i] == a)) return i;
        return -1;
    endfunction

    task automatic chk(logic ok, string tag, string what, longint act, longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic set_idle();
        lk_valid = 0; fill_valid = 0; fence = 0; root_wr = 0; lk_user = 0; lk_acc = 0;
    endtask

    // Check the outputs for the inputs driven now, then clock and update the model.
    task automatic cyc(string tag);
        int  e, code_e, code_a;
        logic fl;
        string t;
        #1;
        fl = fence || (root_wr && !ctx_tag_en);
        e  = find(lk_vpn, lk_asid);
        if (!lk_valid) code_e = 0;
        else if (fl || e < 0) code_e = 2;
        else if (exp_allow(m_flg[e], lk_acc, lk_user)) code_e = 1;
        else code_e = 3;
        code_a = (lk_hit && !lk_miss && !lk_fault) ? 1 :
                 (!lk_hit && lk_miss && !lk_fault) ? 2 :
                 (!lk_hit && !lk_miss && lk_fault) ? 3 :
                 (!lk_hit && !lk_miss && !lk_fault) ? 0 : 7;
        t = tag;
        if (t == "") t = (code_e == 1) ? "R1" : (code_e == 3) ? "R9" :
                         (code_e == 2 && fl) ? "R10" : "R2";
        if (lk_valid || tag != "") chk(code_a == code_e, t, "result", code_a, code_e);
        if (lk_valid && (code_e == 1 || code_e == 3) && !fl) begin
            chk(lk_ppn == m_ppn[e], t, "ppn", lk_ppn, m_ppn[e]);
            chk(lk_flags == m_flg[e], t, "flags", lk_flags, m_flg[e]);
        end
        @(posedge clk);
        if (fl) begin
            for (int i = 0; i < N; i++) m_vld[i] = 0;
        end else if (fill_valid) begin
            e = find(fill_vpn, fill_asid);
            if (e < 0) begin
                e = m_ptr;
                m_ptr = (m_ptr + 1) % N;
            end
            m_vld[e] = 1; m_vpn[e] = fill_vpn; m_asid[e] = fill_asid;
            m_ppn[e] = fill_ppn; m_flg[e] = fill_flags;
        end
        @(negedge clk);
        set_idle();
    endtask

    task automatic do_fill(logic [26:0] v, logic [15:0] a, logic [43:0] p, logic [7:0] f);
        fill_valid = 1; fill_vpn = v; fill_asid = a; fill_ppn = p; fill_flags = f;
        cyc("");
    endtask

    task automatic do_look(logic [26:0] v, logic [15:0] a, logic [1:0] acc, logic usr, string tag);
        lk_valid = 1; lk_vpn = v; lk_asid = a; lk_acc = acc; lk_user = usr;
        cyc(tag);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails + 1, checks + 1);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        for (int i = 0; i < N; i++) begin
            m_vld[i] = 0; m_vpn[i] = 0; m_asid[i] = 0; m_ppn[i] = 0; m_flg[i] = 0;
        end
        m_ptr = 0;
        repeat (3) @(negedge clk);
        rst = 0;

        // R11: nothing cached after reset
        do_look(27'h0, 16'h0, 2'd0, 0, "R11");
        do_look(27'h1234, 16'h0, 2'd0, 0, "R11");

        // R3 / R1: install then hit next cycle
        do_fill(27'h100, 16'h1, 44'hCAFE, 8'h1F);
        do_look(27'h100, 16'h1, 2'd0, 0, "R3");
        do_look(27'h100, 16'h1, 2'd2, 1, "R1");

        // R5: duplicate fill rewrites slot 0 in place
        do_fill(27'h100, 16'h1, 44'hBEEF, 8'h1F);
        do_look(27'h100, 16'h1, 2'd1, 0, "R5");
        // R4: 15 more new keys take slots 1..15; slot 0 survives
        for (int i = 1; i < 16; i++) do_fill(27'h200 + i, 16'h1, 44'h300 + i, 8'h07);
        do_look(27'h100, 16'h1, 2'd0, 0, "R4");
        do_fill(27'h2FF, 16'h1, 44'h999, 8'h07);
        do_look(27'h100, 16'h1, 2'd0, 0, "R4");
        do_look(27'h201, 16'h1, 2'd0, 0, "R4");

        // R9: read-only page, store faults, load still hits afterwards
        do_fill(27'h500, 16'h1, 44'h77, 8'h03);
        do_look(27'h500, 16'h1, 2'd1, 0, "R9");
        do_look(27'h500, 16'h1, 2'd0, 1, "R9");
        do_look(27'h500, 16'h1, 2'd3, 0, "R9");
        do_look(27'h500, 16'h1, 2'd0, 0, "R9");

        // R10: lookup and fill in the fence cycle
        fence = 1; fill_valid = 1; fill_vpn = 27'h600; fill_asid = 1; fill_ppn = 44'h5; fill_flags = 8'h03;
        lk_valid = 1; lk_vpn = 27'h500; lk_asid = 1;
        cyc("R10");
        do_look(27'h600, 16'h1, 2'd0, 0, "R10");
        // R6: everything gone after the fence
        do_look(27'h500, 16'h1, 2'd0, 0, "R6");

        // R8 / R7 with tagging on
        do_fill(27'h5, 16'h1, 44'hA1, 8'h03);
        do_look(27'h5, 16'h2, 2'd0, 0, "R8");
        root_wr = 1; cyc("R7");
        do_look(27'h5, 16'h1, 2'd0, 0, "R7");

        // tagging off
        fence = 1; cyc("R6");
        ctx_tag_en = 0;
        do_fill(27'h5, 16'h1, 44'hA2, 8'h03);
        do_look(27'h5, 16'h2, 2'd0, 0, "R8");
        root_wr = 1; cyc("R7");
        do_look(27'h5, 16'h1, 2'd0, 0, "R7");

        // random phases
        for (int ph = 0; ph < 4; ph++) begin
            fence = 1; cyc("R6");
            ctx_tag_en = ph[0];
            for (int k = 0; k < 3000; k++) begin
                int r;
                r = $urandom % 100;
                lk_valid = ($urandom % 100) < 70;
                lk_vpn = 27'($urandom % 24); lk_asid = 16'($urandom % 3);
                lk_acc = 2'($urandom % 4); lk_user = $urandom % 2;
                if (r < 35) begin
                    fill_valid = 1;
                    fill_vpn = 27'($urandom % 24); fill_asid = 16'($urandom % 3);
                    fill_ppn = {12'($urandom), 32'($urandom)};
                    fill_flags = 8'($urandom);
                    fill_flags[0] = ($urandom % 10) != 0;
                end
                fence = ($urandom % 100) < 2;
                root_wr = ($urandom % 100) < 3;
                cyc("");
            end
        end

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule